// File: doc/BRIEF.md
# Partial Configuration Stream Sequencer

This block produces the complete 32-bit word stream that loads one region of a partially reconfigurable fabric through the fabric's internal configuration port. A request on `start` samples four run-time values: the target frame address, the payload length in frames, the device identity word and the checksum word. The block then sends a fixed sequence on a valid/ready output. The sequence opens with bus-width detection words and the synchronisation word. It then writes the register packets that reset the checksum, check the device identity, issue the write-configuration command and set the frame address. Next comes a frame-data write whose header holds the exact payload length. The payload words pass straight through from a payload input stream. A fixed trailer closes the sequence and ends with the desynchronise command.

The payload is a whole number of frames of 41 words each. The block checks the payload stream against the declared length. A payload that ends early is padded up to the declared count. A payload that runs long has its excess words consumed and dropped. In both cases an error flag is raised and the trailer is still sent, so the configuration port always receives a well-formed stream. A one-cycle `done` pulse marks the end of each job.

Top module: `cfg_stream_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err_len`, `cfg_valid` and `pl_ready` are all 0. Whenever `busy` is 0, both `cfg_valid` and `pl_ready` stay 0.
- R2: A job sends 13 leading words in this order: 0x000000BB, 0x11220044, 0xAA995566, 0x30008001, 0x00000007, 0x30018001, device id, 0x30008001, 0x00000001, 0x30002001, frame address, 0x30004000, length word. Register-write headers use the format bits[31:29]=001, bits[28:27]=10, bits[17:13]=register (command 0x04, id 0x0C, frame address 0x01, frame data 0x02), bits[10:0]=word count.
- R3: The length word is 0x50000000 with the payload count, frames×41, in bits[26:0]. Exactly that many payload words follow it, each copied unchanged from `pl_data`.
- R4: The 12 trailing words are, in order: 0x3000C001, 0x00000000, 0x30030001, 0x00000000, 0x30008001, 0x00000003, 0x30002001, 0x00EF8000, 0x30000001, checksum word, 0x30008001, 0x0000000D.
- R5: While `cfg_valid` is 1 and `cfg_ready` is 0, the output word stays stable, the sequence does not advance and no payload word is consumed.
- R6: `done` is 1 for exactly one cycle: the cycle after the final 0x0000000D word is accepted. `busy` is 0 in that cycle.
- R7: If `pl_last` arrives on a payload word before the declared count is reached, `err_len` rises. The remaining payload slots are filled with 0x00000000 words and the trailer follows.
- R8: If the word that fills the declared count lacks `pl_last`, `err_len` rises. Further payload words are accepted and dropped, with none sent out, up to and including the word marked `pl_last`. The trailer then follows.
- R9: With zero frames, the length word is 0x50000000, no payload word is consumed, and the trailer follows the length word directly.
- R10: `start` is ignored while `busy` is 1. The frame address, frame count, device id and checksum inputs are sampled only when a job starts, and later changes have no effect on that job.
- R11: `err_len` holds its value until the next accepted `start`. It is 0 in the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| err_len | output | 1 | Payload length mismatch seen in the last job |
| frame_addr | input | 32 | Target frame address, sampled at start |
| num_frames | input | FRAME_W | Payload length in frames, sampled at start |
| dev_id | input | 32 | Device identity word, sampled at start |
| crc_word | input | 32 | Checksum word for the trailer, sampled at start |
| pl_data | input | 32 | Payload word |
| pl_valid | input | 1 | Payload word present |
| pl_last | input | 1 | Marks the final payload word |
| pl_ready | output | 1 | Payload word taken |
| cfg_data | output | 32 | Configuration word |
| cfg_valid | output | 1 | Configuration word present |
| cfg_ready | input | 1 | Configuration port accepts the word |

## Verification
Jobs of one, two and zero frames tell apart a correct length word and a correct splice point from off-by-one or missing-payload faults. Payloads with gaps in `pl_valid` and a configuration port that stalls on varying patterns separate true flow control from sequences that advance on a timer or drop words under stall. Short and long payloads show padding against draining and test that the trailer still follows. A job run after an errored one, with a stray `start` mid-job and inputs changed after start, shows that the error flag clears and that inputs are sampled only at start.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int unsigned IDX_W    = 4;
  localparam int unsigned PRE_LEN  = 13;
  localparam int unsigned POST_LEN = 12;

  localparam logic [31:0] W_BUSW_A   = 32'h000000BB;
  localparam logic [31:0] W_BUSW_B   = 32'h11220044;
  localparam logic [31:0] W_SYNC     = 32'hAA995566;
  localparam logic [31:0] W_TAIL_FAR = 32'h00EF8000;

  localparam logic [4:0] RA_CRC   = 5'h00;
  localparam logic [4:0] RA_FADDR = 5'h01;
  localparam logic [4:0] RA_FDATA = 5'h02;
  localparam logic [4:0] RA_CMD   = 5'h04;
  localparam logic [4:0] RA_MASK  = 5'h06;
  localparam logic [4:0] RA_IDENT = 5'h0C;
  localparam logic [4:0] RA_CTL1  = 5'h18;

  localparam logic [31:0] OP_WCFG   = 32'h00000001;
  localparam logic [31:0] OP_LFRM   = 32'h00000003;
  localparam logic [31:0] OP_RCRC   = 32'h00000007;
  localparam logic [31:0] OP_DESYNC = 32'h0000000D;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_DATA, PH_PAD, PH_DRAIN, PH_POST
  } phase_t;

  function automatic logic [31:0] hdr_short(input logic [4:0] ra, input logic [10:0] n);
    return {3'b001, 2'b10, 9'd0, ra, 2'b00, n};
  endfunction

  function automatic logic [31:0] hdr_long(input logic [26:0] n);
    return {3'b010, 2'b10, n};
  endfunction

  function automatic logic [31:0] lead_word(input logic [IDX_W-1:0] idx,
                                            input logic [31:0] dev,
                                            input logic [31:0] far,
                                            input logic [26:0] n);
    case (idx)
      4'd0:    return W_BUSW_A;
      4'd1:    return W_BUSW_B;
      4'd2:    return W_SYNC;
      4'd3:    return hdr_short(RA_CMD, 11'd1);
      4'd4:    return OP_RCRC;
      4'd5:    return hdr_short(RA_IDENT, 11'd1);
      4'd6:    return dev;
      4'd7:    return hdr_short(RA_CMD, 11'd1);
      4'd8:    return OP_WCFG;
      4'd9:    return hdr_short(RA_FADDR, 11'd1);
      4'd10:   return far;
      4'd11:   return hdr_short(RA_FDATA, 11'd0);
      4'd12:   return hdr_long(n);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] trail_word(input logic [IDX_W-1:0] idx,
                                             input logic [31:0] crc,
                                             input logic [31:0] mask_v,
                                             input logic [31:0] ctl1_v);
    case (idx)
      4'd0:    return hdr_short(RA_MASK, 11'd1);
      4'd1:    return mask_v;
      4'd2:    return hdr_short(RA_CTL1, 11'd1);
      4'd3:    return ctl1_v;
      4'd4:    return hdr_short(RA_CMD, 11'd1);
      4'd5:    return OP_LFRM;
      4'd6:    return hdr_short(RA_FADDR, 11'd1);
      4'd7:    return W_TAIL_FAR;
      4'd8:    return hdr_short(RA_CRC, 11'd1);
      4'd9:    return crc;
      4'd10:   return hdr_short(RA_CMD, 11'd1);
      4'd11:   return OP_DESYNC;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_ctx.sv
module cfg_seq_ctx #(
  parameter int FRAME_W         = 8,
  parameter int WORDS_PER_FRAME = 41,
  parameter int CNT_W           = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [31:0]        frame_addr,
  input  logic [FRAME_W-1:0] num_frames,
  input  logic [31:0]        dev_id,
  input  logic [31:0]        crc_word,
  output logic [31:0]        far_q,
  output logic [31:0]        dev_q,
  output logic [31:0]        crc_q,
  output logic [CNT_W-1:0]   cnt_q
);

  function automatic logic [CNT_W-1:0] frames_to_words(input logic [FRAME_W-1:0] f);
    return CNT_W'(f) * CNT_W'(WORDS_PER_FRAME);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      far_q <= '0;
      dev_q <= '0;
      crc_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      far_q <= frame_addr;
      dev_q <= dev_id;
      crc_q <= crc_word;
      cnt_q <= frames_to_words(num_frames);
    end
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cfg_fire,
  input  logic             pl_fire,
  input  logic             pl_last,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             busy,
  output logic             done,
  output logic             err_len,
  output logic             short_evt,
  output logic             long_evt
);

  logic [CNT_W-1:0] dcnt;
  logic             lead_end;
  logic             trail_end;
  logic             slot_end;

  assign load      = start && (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign lead_end  = (idx == IDX_W'(PRE_LEN - 1));
  assign trail_end = (idx == IDX_W'(POST_LEN - 1));
  assign slot_end  = (dcnt == cnt_q - CNT_W'(1));
  assign short_evt = (phase == PH_DATA) && cfg_fire && !slot_end && pl_last;
  assign long_evt  = (phase == PH_DATA) && cfg_fire && slot_end && !pl_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      dcnt    <= '0;
      done    <= 1'b0;
      err_len <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_PRE;
            idx     <= '0;
            err_len <= 1'b0;
          end
        end
        PH_PRE: begin
          if (cfg_fire) begin
            if (lead_end) begin
              idx   <= '0;
              dcnt  <= '0;
              phase <= (cnt_q == '0) ? PH_POST : PH_DATA;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (cfg_fire) begin
            dcnt <= dcnt + CNT_W'(1);
            if (slot_end) begin
              if (!pl_last) begin
                err_len <= 1'b1;
                phase   <= PH_DRAIN;
              end else begin
                phase <= PH_POST;
              end
            end else if (pl_last) begin
              err_len <= 1'b1;
              phase   <= PH_PAD;
            end
          end
        end
        PH_PAD: begin
          if (cfg_fire) begin
            dcnt <= dcnt + CNT_W'(1);
            if (slot_end) phase <= PH_POST;
          end
        end
        PH_DRAIN: begin
          if (pl_fire && pl_last) phase <= PH_POST;
        end
        PH_POST: begin
          if (cfg_fire) begin
            if (trail_end) begin
              phase <= PH_IDLE;
              idx   <= '0;
              done  <= 1'b1;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_seq_wordmux.sv
module cfg_seq_wordmux
  import cfg_seq_pkg::*;
#(
  parameter int          CNT_W    = 14,
  parameter logic [31:0] MASK_VAL = 32'h0,
  parameter logic [31:0] CTL1_VAL = 32'h0,
  parameter logic [31:0] PAD_WORD = 32'h0
) (
  input  phase_t           phase,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      far_q,
  input  logic [31:0]      dev_q,
  input  logic [31:0]      crc_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [31:0]      pl_data,
  input  logic             pl_valid,
  input  logic             cfg_ready,
  output logic [31:0]      cfg_data,
  output logic             cfg_valid,
  output logic             pl_ready
);

  always_comb begin
    cfg_data  = '0;
    cfg_valid = 1'b0;
    pl_ready  = 1'b0;
    case (phase)
      PH_PRE: begin
        cfg_valid = 1'b1;
        cfg_data  = lead_word(idx, dev_q, far_q, 27'(cnt_q));
      end
      PH_DATA: begin
        cfg_valid = pl_valid;
        cfg_data  = pl_data;
        pl_ready  = cfg_ready;
      end
      PH_PAD: begin
        cfg_valid = 1'b1;
        cfg_data  = PAD_WORD;
      end
      PH_DRAIN: begin
        pl_ready = 1'b1;
      end
      PH_POST: begin
        cfg_valid = 1'b1;
        cfg_data  = trail_word(idx, crc_q, MASK_VAL, CTL1_VAL);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
  import cfg_seq_pkg::*;
#(
  parameter int          FRAME_W         = 8,
  parameter int          WORDS_PER_FRAME = 41,
  parameter logic [31:0] MASK_VAL        = 32'h0,
  parameter logic [31:0] CTL1_VAL        = 32'h0,
  parameter logic [31:0] PAD_WORD        = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               err_len,
  input  logic [31:0]        frame_addr,
  input  logic [FRAME_W-1:0] num_frames,
  input  logic [31:0]        dev_id,
  input  logic [31:0]        crc_word,
  input  logic [31:0]        pl_data,
  input  logic               pl_valid,
  input  logic               pl_last,
  output logic               pl_ready,
  output logic [31:0]        cfg_data,
  output logic               cfg_valid,
  input  logic               cfg_ready
);

  localparam int MAX_WORDS = ((1 << FRAME_W) - 1) * WORDS_PER_FRAME;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic             load;
  logic [31:0]      far_q;
  logic [31:0]      dev_q;
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cfg_fire;
  logic             pl_fire;
  logic             short_evt;
  logic             long_evt;

  assign cfg_fire = cfg_valid && cfg_ready;
  assign pl_fire  = pl_valid && pl_ready;

  cfg_seq_ctx #(
    .FRAME_W(FRAME_W), .WORDS_PER_FRAME(WORDS_PER_FRAME), .CNT_W(CNT_W)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(load),
    .frame_addr(frame_addr), .num_frames(num_frames),
    .dev_id(dev_id), .crc_word(crc_word),
    .far_q(far_q), .dev_q(dev_q), .crc_q(crc_q), .cnt_q(cnt_q)
  );

  cfg_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_q(cnt_q),
    .cfg_fire(cfg_fire), .pl_fire(pl_fire), .pl_last(pl_last),
    .phase(phase), .idx(idx), .load(load), .busy(busy), .done(done),
    .err_len(err_len), .short_evt(short_evt), .long_evt(long_evt)
  );

  cfg_seq_wordmux #(
    .CNT_W(CNT_W), .MASK_VAL(MASK_VAL), .CTL1_VAL(CTL1_VAL), .PAD_WORD(PAD_WORD)
  ) u_mux (
    .phase(phase), .idx(idx), .far_q(far_q), .dev_q(dev_q), .crc_q(crc_q),
    .cnt_q(cnt_q), .pl_data(pl_data), .pl_valid(pl_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .pl_ready(pl_ready)
  );

endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err_len,
  input logic [31:0] cfg_data,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        pl_ready,
  input logic        short_evt,
  input logic        long_evt
);

  // R1: nothing offered or taken while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_valid && !pl_ready));

  // R2: a job opens with the first bus-width word
  p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cfg_valid && cfg_data == 32'h000000BB));

  // R5: stalled word held
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done follows acceptance of the desynchronise word
  p_done_after_desync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cfg_valid && cfg_ready && cfg_data == 32'h0000000D));

  // R7, R8: a length mismatch raises the flag
  p_err_on_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_evt || long_evt) |=> err_len);

  // R11: flag held until an accepted start
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_len && !(start && !busy)) |=> err_len);

endmodule

bind cfg_stream_seq cfg_stream_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_len(err_len), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .pl_ready(pl_ready),
  .short_evt(short_evt), .long_evt(long_evt)
);

// File: tb/cfg_stream_seq_test.sv
module cfg_stream_seq_test;

  localparam int FRAME_W = 8;
  localparam int WPF     = 41;
  localparam int MAXW    = 1024;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               busy, done, err_len;
  logic [31:0]        frame_addr = '0;
  logic [FRAME_W-1:0] num_frames = '0;
  logic [31:0]        dev_id = '0;
  logic [31:0]        crc_word = '0;
  logic [31:0]        pl_data = '0;
  logic               pl_valid = 1'b0;
  logic               pl_last = 1'b0;
  logic               pl_ready;
  logic [31:0]        cfg_data;
  logic               cfg_valid;
  logic               cfg_ready = 1'b0;

  always #4 clk = ~clk;

  cfg_stream_seq #(.FRAME_W(FRAME_W), .WORDS_PER_FRAME(WPF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err_len(err_len), .frame_addr(frame_addr), .num_frames(num_frames),
    .dev_id(dev_id), .crc_word(crc_word), .pl_data(pl_data),
    .pl_valid(pl_valid), .pl_last(pl_last), .pl_ready(pl_ready),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int ready_mode = 0;
  bit finished = 0;

  logic [31:0] got   [0:MAXW-1];
  logic [31:0] exp_w [0:MAXW-1];
  int got_n, exp_n;
  int done_cnt, done_cyc, last_acc_cyc, hold_bad, plr_cnt;
  logic [31:0] held_word;
  bit held_pending = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      1:       cfg_ready = (cyc % 3) != 0;
      2:       cfg_ready = (cyc % 5) < 2;
      default: cfg_ready = 1'b1;
    endcase
  end

  // observer, sampling between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pending && (!cfg_valid || cfg_data !== held_word)) hold_bad++;
      held_pending = cfg_valid && !cfg_ready;
      held_word    = cfg_data;
      if (cfg_valid && cfg_ready) begin
        if (got_n < MAXW) got[got_n] = cfg_data;
        got_n++;
        last_acc_cyc = cyc;
      end
      if (pl_ready) plr_cnt++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] pword(input logic [31:0] seed, input int i);
    return seed ^ (32'(i) * 32'h9E3779B1) ^ 32'h0000_5A00;
  endfunction

  task automatic push(input logic [31:0] w);
    exp_w[exp_n] = w;
    exp_n++;
  endtask

  // expected stream written directly from the requirement text
  task automatic build_exp(input logic [31:0] far, input logic [31:0] id,
                           input logic [31:0] crc, input int n,
                           input int supplied, input logic [31:0] seed);
    exp_n = 0;
    push(32'h000000BB); push(32'h11220044); push(32'hAA995566);
    push(32'h30008001); push(32'h00000007);
    push(32'h30018001); push(id);
    push(32'h30008001); push(32'h00000001);
    push(32'h30002001); push(far);
    push(32'h30004000); push(32'h50000000 + 32'(n));
    for (int i = 0; i < n; i++) push((i < supplied) ? pword(seed, i) : 32'h0);
    push(32'h3000C001); push(32'h00000000);
    push(32'h30030001); push(32'h00000000);
    push(32'h30008001); push(32'h00000003);
    push(32'h30002001); push(32'h00EF8000);
    push(32'h30000001); push(crc);
    push(32'h30008001); push(32'h0000000D);
  endtask

  task automatic feed(input logic [31:0] seed, input int supplied, input bit gap);
    for (int i = 0; i < supplied; i++) begin
      if (gap && (i % 4) == 1) begin
        pl_valid = 1'b0;
        pl_last  = 1'b0;
        @(posedge clk); #1;
      end
      pl_data  = pword(seed, i);
      pl_valid = 1'b1;
      pl_last  = (i == supplied - 1);
      do @(negedge clk); while (!pl_ready);
      @(posedge clk); #1;
    end
    pl_valid = 1'b0;
    pl_last  = 1'b0;
  endtask

  task automatic run_job(input string req, input int frames, input int supplied,
                         input int rmode, input bit gap, input bit poke,
                         input bit exp_err, input logic [31:0] seed);
    logic [31:0] far;
    logic [31:0] crc;
    int n, t, mism;
    far = 32'h0040_0000 + seed[15:0];
    crc = seed ^ 32'hC3C3_0F0F;
    n   = frames * WPF;
    build_exp(far, 32'h02AD6093, crc, n, supplied, seed);
    ready_mode = rmode;
    @(posedge clk); #1;
    got_n = 0; done_cnt = 0; hold_bad = 0; plr_cnt = 0;
    frame_addr = far; dev_id = 32'h02AD6093; crc_word = crc;
    num_frames = FRAME_W'(frames); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(err_len == 1'b0, "R11", {req, " err cleared by start"}, 32'(err_len), 32'h0);
    check(busy == 1'b1, "R10", {req, " busy after start"}, 32'(busy), 32'h1);
    // R10: inputs changed after sampling must not matter
    frame_addr = ~far; dev_id = 32'h0; crc_word = ~crc;
    num_frames = FRAME_W'(frames + 1);
    fork
      feed(seed, supplied, gap);
      begin
        if (poke) begin
          repeat (7) @(posedge clk);
          #1; start = 1'b1;
          @(posedge clk); #1; start = 1'b0;
        end
      end
    join
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(posedge clk); t++;
    end
    repeat (4) @(posedge clk);
    #1;
    check(got_n == exp_n, "R3", {req, " stream length"}, 32'(got_n), 32'(exp_n));
    mism = -1;
    for (int i = 0; i < exp_n && i < got_n && i < MAXW; i++)
      if (mism < 0 && got[i] !== exp_w[i]) mism = i;
    if (mism >= 0)
      check(1'b0, req, $sformatf("word %0d", mism), got[mism], exp_w[mism]);
    else
      check(1'b1, req, "words", 32'h0, 32'h0);
    check(err_len == exp_err, exp_err ? "R7" : "R11", {req, " err_len"},
          32'(err_len), 32'(exp_err));
    check(done_cnt == 1, "R6", {req, " done pulses"}, 32'(done_cnt), 32'h1);
    check(done_cyc == last_acc_cyc + 1, "R6", {req, " done timing"},
          32'(done_cyc), 32'(last_acc_cyc + 1));
    check(busy == 1'b0 && cfg_valid == 1'b0, "R1", {req, " idle after job"},
          {busy, cfg_valid}, 32'h0);
    if (rmode != 0)
      check(hold_bad == 0, "R5", {req, " stall stability"}, 32'(hold_bad), 32'h0);
    if (frames == 0)
      check(plr_cnt == 0, "R9", {req, " no payload taken"}, 32'(plr_cnt), 32'h0);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check({busy, done, err_len, cfg_valid, pl_ready} == 5'b0, "R1", "reset state",
          32'({busy, done, err_len, cfg_valid, pl_ready}), 32'h0);
  endtask

  task automatic test_basic;      run_job("R2", 1, WPF, 0, 1'b0, 1'b0, 1'b0, 32'h1111_0001); endtask
  task automatic test_stall;      run_job("R5", 2, 2*WPF, 1, 1'b1, 1'b0, 1'b0, 32'h2222_0002); endtask
  task automatic test_trailer;    run_job("R4", 1, WPF, 2, 1'b1, 1'b0, 1'b0, 32'h3333_0003); endtask
  task automatic test_zero;       run_job("R9", 0, 0, 1, 1'b0, 1'b0, 1'b0, 32'h4444_0004); endtask
  task automatic test_short;      run_job("R7", 1, WPF-5, 1, 1'b1, 1'b0, 1'b1, 32'h5555_0005); endtask
  task automatic test_clear;      run_job("R11", 1, WPF, 0, 1'b0, 1'b0, 1'b0, 32'h6666_0006); endtask
  task automatic test_long;       run_job("R8", 1, WPF+3, 2, 1'b0, 1'b0, 1'b1, 32'h7777_0007); endtask
  task automatic test_busy_start; run_job("R10", 1, WPF, 1, 1'b0, 1'b1, 1'b0, 32'h8888_0008); endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset;
    test_basic;
    test_stall;
    test_trailer;
    test_zero;
    test_short;
    test_clear;
    test_long;
    test_busy_start;
    finished = 1;
    summary;
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R6 watchdog: actual=%h expected=%h", 32'(done_cnt), 32'h1);
      summary;
      $finish;
    end
  end

endmodule